// File: doc/BRIEF.md
# Bit-Serial SIMD Row Processor

This block couples a small storage array to a row of identical one-bit processing elements, one element per column. A single broadcast instruction names a storage row, an 8-bit function code and a destination. Every element then forms a 3-bit index from its own two register bits and its own bit of the named row. It uses that index to pick one bit of the function code. All columns act in the same cycle, so an arbitrary 3-input Boolean function is applied across the whole row at once. Multi-bit arithmetic is built as a sequence of such steps, one bit position at a time.

The result vector goes to a result output. It can also be kept in either register of every element, or stored back into the named row. A host port reads and writes whole rows of the array while no instruction is being issued. Instructions are never back-pressured: a new one may be presented on every cycle. The host request stream uses a valid/ready handshake. `host_ready` is low in any cycle where `ins_valid` is high, and a host request is accepted only in a cycle where both `host_valid` and `host_ready` are high. A host read answers with a one-cycle `rsp_valid` pulse that has no ready of its own.

Top module: `simd_row_array`

## Requirements
- R1: A synchronous reset clears the first and second register of every element, and clears `res_valid` and `rsp_valid`; on the first cycle after reset `pe_x` and `pe_y` read all zeros.
- R2: For an instruction accepted at a clock edge, `res_data[c]` after that edge equals `ins_fn[{x[c], y[c], m[c]}]`. Here x and y are column c's register bits before the edge, m is column c's bit of row `ins_row`, and the register bit x is the most significant index bit. `res_valid` is high for exactly the cycles following an accepted instruction.
- R3: Destination code 1 loads the result vector into the first registers (`pe_x`) and leaves `pe_y` and the array unchanged.
- R4: Destination code 2 loads the result vector into the second registers (`pe_y`) and leaves `pe_x` and the array unchanged.
- R5: Destination code 3 writes the result vector into every column of row `ins_row` at the issuing edge; other rows, `pe_x` and `pe_y` are unchanged.
- R6: Destination code 0 changes neither registers nor array, yet still produces the result vector; cycles without `ins_valid` change no register.
- R7: Instructions issue back to back without stalls; an instruction reads the row contents left by the instruction of the previous cycle.
- R8: While `ins_valid` is high, `host_ready` is low and a pending host write does not reach the array. An accepted host write stores `host_wdata` into row `host_addr`. An accepted host read returns that row on `rsp_data` with `rsp_valid` high in the next cycle only.
- R9: With function codes 8'hE8 (majority, the carry) and 8'h96 (three-input parity, the sum), a sequence of row operations adds two multi-bit operands stored one bit per row, separately in every column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_row | input | ROW_W | Storage row read (and written for destination 3) |
| ins_dst | input | 2 | Destination: 0 none, 1 first register, 2 second register, 3 row |
| ins_fn | input | 8 | Broadcast truth table indexed by {x, y, m} |
| res_valid | output | 1 | Result vector of the previous cycle's instruction is valid |
| res_data | output | COLS | Result vector, one bit per column |
| pe_x | output | COLS | First register of every element |
| pe_y | output | COLS | Second register of every element |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Host request may be accepted this cycle |
| host_we | input | 1 | 1 = write request, 0 = read request |
| host_addr | input | ROW_W | Row addressed by the host |
| host_wdata | input | COLS | Row data for a host write |
| rsp_valid | output | 1 | Host read data valid |
| rsp_data | output | COLS | Row returned by a host read |

## Verification
The host port and the instruction stream compete for the array's write path. A host write held pending while instructions issue is the collision that matters. The bench holds a host write to a row valid across two instructions that copy that same row into the first and then the second registers. It judges that `host_ready` stays low and that both registers receive the row's old contents. Once the instruction stream pauses, it judges that the write lands and reads back correctly.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_X    = 2'd1,
    DST_Y    = 2'd2,
    DST_ROW  = 2'd3
  } dst_e;
endpackage

// File: rtl/row_store.sv
module row_store #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [COLS-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [COLS-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [COLS-1:0] rdata_b
);
  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/bit_pe.sv
module bit_pe #(
  parameter int FN_W = 8,
  localparam int SEL_W = $clog2(FN_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_x,
  input  logic            load_y,
  input  logic            mem_bit,
  input  logic [FN_W-1:0] fn,
  output logic            res,
  output logic            x_q,
  output logic            y_q
);
  logic [SEL_W-1:0] sel;

  assign sel = {x_q, y_q, mem_bit};
  assign res = fn[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= 1'b0;
      y_q <= 1'b0;
    end else begin
      if (load_x) x_q <= res;
      if (load_y) y_q <= res;
    end
  end
endmodule

// File: rtl/simd_row_array.sv
module simd_row_array #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int ROW_W = $clog2(ROWS),
  localparam int FN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [ROW_W-1:0] ins_row,
  input  logic [1:0]       ins_dst,
  input  logic [FN_W-1:0]  ins_fn,
  output logic             res_valid,
  output logic [COLS-1:0]  res_data,
  output logic [COLS-1:0]  pe_x,
  output logic [COLS-1:0]  pe_y,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             host_we,
  input  logic [ROW_W-1:0] host_addr,
  input  logic [COLS-1:0]  host_wdata,
  output logic             rsp_valid,
  output logic [COLS-1:0]  rsp_data
);
  import simd_pkg::*;

  dst_e            dst;
  logic            go_x, go_y, go_row;
  logic            host_fire, host_rd;
  logic [COLS-1:0] row_bits, host_bits, res_vec;
  logic            st_we;
  logic [ROW_W-1:0] st_addr;
  logic [COLS-1:0] st_data;

  assign dst    = dst_e'(ins_dst);
  assign go_x   = ins_valid && (dst == DST_X);
  assign go_y   = ins_valid && (dst == DST_Y);
  assign go_row = ins_valid && (dst == DST_ROW);

  // instructions own the array; host waits
  assign host_ready = ~ins_valid;
  assign host_fire  = host_valid && host_ready;
  assign host_rd    = host_fire && !host_we;

  assign st_we   = go_row || (host_fire && host_we);
  assign st_addr = ins_valid ? ins_row : host_addr;
  assign st_data = ins_valid ? res_vec : host_wdata;

  row_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk     (clk),
    .we      (st_we),
    .waddr   (st_addr),
    .wdata   (st_data),
    .raddr_a (ins_row),
    .rdata_a (row_bits),
    .raddr_b (host_addr),
    .rdata_b (host_bits)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    bit_pe #(.FN_W(FN_W)) u_pe (
      .clk     (clk),
      .rst     (rst),
      .load_x  (go_x),
      .load_y  (go_y),
      .mem_bit (row_bits[c]),
      .fn      (ins_fn),
      .res     (res_vec[c]),
      .x_q     (pe_x[c]),
      .y_q     (pe_y[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      res_valid <= ins_valid;
      rsp_valid <= host_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) res_data <= res_vec;
    if (host_rd)   rsp_data <= host_bits;
  end
endmodule

// File: rtl/simd_row_array_chk.sv
module simd_row_array_chk #(
  parameter int COLS = 16,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic [1:0]       ins_dst,
  input logic             res_valid,
  input logic [COLS-1:0]  pe_x,
  input logic [COLS-1:0]  pe_y,
  input logic             host_valid,
  input logic             host_ready,
  input logic             host_we,
  input logic             rsp_valid
);
  a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pe_x == '0 && pe_y == '0 && !res_valid && !rsp_valid));

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> res_valid);

  a_r2_no_stray_result: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> !res_valid);

  a_r3_x_keeps_y: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_dst == 2'd1) |=> $stable(pe_y));

  a_r4_y_keeps_x: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_dst == 2'd2) |=> $stable(pe_x));

  a_r5_row_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_dst == 2'd3) |=> ($stable(pe_x) && $stable(pe_y)));

  a_r6_none_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (!ins_valid || ins_dst == 2'd0) |=> ($stable(pe_x) && $stable(pe_y)));

  a_r8_read_answers: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready && !host_we) |=> rsp_valid);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !(host_valid && host_ready && !host_we) |=> !rsp_valid);

  a_r8_blocked_no_reply: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> !rsp_valid);
endmodule

bind simd_row_array simd_row_array_chk #(.COLS(COLS), .ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ins_valid  (ins_valid),
  .ins_dst    (ins_dst),
  .res_valid  (res_valid),
  .pe_x       (pe_x),
  .pe_y       (pe_y),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .host_we    (host_we),
  .rsp_valid  (rsp_valid)
);

// File: tb/test_simd_row_array.sv
module test_simd_row_array;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int ROW_W = $clog2(ROWS);
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0;
  logic [ROW_W-1:0] ins_row = '0;
  logic [1:0] ins_dst = '0;
  logic [7:0] ins_fn = '0;
  logic res_valid;
  logic [COLS-1:0] res_data, pe_x, pe_y;
  logic host_valid = 1'b0;
  logic host_ready;
  logic host_we = 1'b0;
  logic [ROW_W-1:0] host_addr = '0;
  logic [COLS-1:0] host_wdata = '0;
  logic rsp_valid;
  logic [COLS-1:0] rsp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [COLS-1:0] mem_m [ROWS];
  logic [COLS-1:0] x_m = '0;
  logic [COLS-1:0] y_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_row_array #(.ROWS(ROWS), .COLS(COLS)) i_simd_row_array (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_row(ins_row),
    .ins_dst(ins_dst), .ins_fn(ins_fn), .res_valid(res_valid),
    .res_data(res_data), .pe_x(pe_x), .pe_y(pe_y),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] d, input int row, input logic [7:0] fn, input string tag);
    logic [COLS-1:0] e;
    ins_valid = 1'b1; ins_dst = d; ins_row = ROW_W'(row); ins_fn = fn;
    for (int c = 0; c < COLS; c++) e[c] = fn[{x_m[c], y_m[c], mem_m[row][c]}];
    @(negedge clk);
    chk(res_valid === 1'b1 && res_data === e, tag, {47'd0, res_valid, res_data}, {47'd0, 1'b1, e});
    case (d)
      2'd1: x_m = e;
      2'd2: y_m = e;
      2'd3: mem_m[row] = e;
      default: ;
    endcase
    chk(pe_x === x_m && pe_y === y_m, tag, {32'd0, pe_x, pe_y}, {32'd0, x_m, y_m});
  endtask

  task automatic idle();
    ins_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_write(input int row, input logic [COLS-1:0] data);
    host_valid = 1'b1; host_we = 1'b1; host_addr = ROW_W'(row); host_wdata = data;
    #1;
    chk(host_ready === 1'b1, "R8 ready", {63'd0, host_ready}, 64'd1);
    @(negedge clk);
    host_valid = 1'b0;
    mem_m[row] = data;
  endtask

  task automatic host_read(input int row, input string tag, output logic [COLS-1:0] got);
    host_valid = 1'b1; host_we = 1'b0; host_addr = ROW_W'(row);
    @(negedge clk);
    host_valid = 1'b0;
    got = rsp_data;
    chk(rsp_valid === 1'b1 && rsp_data === mem_m[row], tag,
        {47'd0, rsp_valid, rsp_data}, {47'd0, 1'b1, mem_m[row]});
  endtask

  task automatic t_reset();
    chk(pe_x === '0 && pe_y === '0, "R1 regs", {32'd0, pe_x, pe_y}, 64'd0);
    chk(!res_valid && !rsp_valid, "R1 valids", {62'd0, res_valid, rsp_valid}, 64'd0);
  endtask

  task automatic t_fill();
    logic [COLS-1:0] g;
    for (int r = 0; r < ROWS; r++) host_write(r, COLS'(16'h3C5A ^ (r * 16'h1357)));
    for (int r = 0; r < ROWS; r++) host_read(r, "R8 readback", g);
    @(negedge clk);
    chk(!rsp_valid, "R8 pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_truth();
    logic [COLS-1:0] g;
    issue(2'd1, 2, 8'hAA, "R3 load x");
    issue(2'd2, 5, 8'hAA, "R4 load y");
    issue(2'd0, 7, 8'hE8, "R6 majority");
    issue(2'd0, 7, 8'h96, "R2 parity");
    issue(2'd0, 9, 8'h1B, "R2 mixed");
    issue(2'd1, 9, 8'h6C, "R3 x fn");
    issue(2'd2, 11, 8'hC3, "R4 y fn");
    idle();
    chk(!res_valid, "R2 no result", {63'd0, res_valid}, 64'd0);
    host_read(7, "R6 row untouched", g);
    host_read(9, "R3 row untouched", g);
    host_read(11, "R4 row untouched", g);
  endtask

  task automatic t_row_write();
    logic [COLS-1:0] g;
    issue(2'd3, 4, 8'h96, "R5 row write");
    idle();
    host_read(4, "R5 row value", g);
    host_read(3, "R5 neighbour below", g);
    host_read(5, "R5 neighbour above", g);
  endtask

  task automatic t_back_to_back();
    issue(2'd3, 6, 8'h55, "R7 invert row");
    issue(2'd1, 6, 8'hAA, "R7 read new row");
    issue(2'd3, 6, 8'hF0, "R7 store x");
    issue(2'd2, 6, 8'hAA, "R7 read again");
    idle();
  endtask

  task automatic t_collide();
    logic [COLS-1:0] g;
    host_write(14, 16'h1234);
    ins_valid = 1'b1; ins_dst = 2'd1; ins_row = ROW_W'(14); ins_fn = 8'hAA;
    host_valid = 1'b1; host_we = 1'b1; host_addr = ROW_W'(14); host_wdata = 16'hBEEF;
    #1;
    chk(host_ready === 1'b0, "R8 blocked", {63'd0, host_ready}, 64'd0);
    issue(2'd1, 14, 8'hAA, "R8 old row to x");
    issue(2'd2, 14, 8'hAA, "R8 old row to y");
    chk(pe_y === 16'h1234, "R8 write held", {48'd0, pe_y}, 64'h1234);
    ins_valid = 1'b0;
    #1;
    chk(host_ready === 1'b1, "R8 released", {63'd0, host_ready}, 64'd1);
    @(negedge clk);
    host_valid = 1'b0;
    mem_m[14] = 16'hBEEF;
    host_read(14, "R8 late write", g);
  endtask

  task automatic t_add(input int k);
    int a [COLS];
    int b [COLS];
    logic [COLS-1:0] rw;
    logic [COLS-1:0] s [NB+1];
    for (int c = 0; c < COLS; c++) begin
      a[c] = (c * 5 + k) % 16;
      b[c] = (c * 11 + 3 * k) % 16;
    end
    for (int i = 0; i < NB; i++) begin
      for (int c = 0; c < COLS; c++) rw[c] = a[c][i];
      host_write(i, rw);
      for (int c = 0; c < COLS; c++) rw[c] = b[c][i];
      host_write(NB + i, rw);
      host_write(2 * NB + i, rw);
    end
    issue(2'd1, 0, 8'h00, "R9 clear carry");
    for (int i = 0; i < NB; i++) begin
      issue(2'd2, i, 8'hAA, "R9 operand a");
      issue(2'd3, 2 * NB + i, 8'h96, "R9 sum bit");
      issue(2'd1, NB + i, 8'hE8, "R9 carry");
    end
    issue(2'd3, 3 * NB, 8'hF0, "R9 carry out");
    idle();
    for (int i = 0; i <= NB; i++) host_read(2 * NB + i, "R9 sum row", s[i]);
    for (int c = 0; c < COLS; c++) begin
      int got = 0;
      for (int i = 0; i <= NB; i++) got |= int'(s[i][c]) << i;
      chk(got == a[c] + b[c], "R9 column sum", 64'(got), 64'(a[c] + b[c]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_truth();
    t_row_write();
    t_back_to_back();
    t_collide();
    t_add(1);
    t_add(7);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule